// File: doc/BRIEF.md
# Time Base and Decrementer Timer

This block is the timer unit of a processor core. It keeps a 64-bit free-running time base and a 32-bit decrementer. Both advance on a common tick that a small prescaler produces once every four bus clock cycles. Software reaches the three registers through one register access port. Reads are allowed at any privilege level. Writes take effect only while the supervisor input is high.

The time base counts up and is seen as two 32-bit halves, and a carry out of the lower half moves into the upper half. The decrementer counts down. When its top bit turns from 0 to 1 while counting, the block raises a level-held exception request. The request stays high until the acknowledge input clears it. Exception vectoring and masking are left to the core that surrounds the block. The whole block runs in the bus clock domain.

Top module: `tbd_timer_top`

## Requirements
- R1: A synchronous active-high reset clears the prescaler, both time base halves and the exception request, and loads the decrementer with all ones.
- R2: The prescaler tick occurs once every four cycles. The first tick is seen at the fourth rising edge after reset is released, and the lower time base half increments by one on each tick.
- R3: On a tick where the lower half is all ones and is not being written, the lower half wraps to zero and the upper half increments in the same cycle.
- R4: A supervisor write loads the selected time base half with the write data and takes priority over the tick update of that half. When the lower half is written, no carry reaches the upper half in that cycle.
- R5: A write while the supervisor input is low changes no register. The privilege-fault output is high in exactly those cycles where the access strobe and the write flag are high and the supervisor input is low.
- R6: The decrementer decreases by one on every tick, wrapping from zero to all ones.
- R7: The exception request goes high on the cycle after a tick moves the decrementer from 0 to all ones, that is when bit 31 changes from 0 to 1. It stays high until a cycle with the acknowledge input high.
- R8: A supervisor write to the decrementer loads the value directly, including over a coincident tick, and never raises the exception request by itself, even when bit 31 of the loaded value is set.
- R9: When the acknowledge input and a new expiry fall in the same cycle, the request is set (set wins over clear).
- R10: The read data reflects the current register value combinationally while the access strobe is high. The select encoding is 0 for the lower time base half, 1 for the upper half and 2 for the decrementer. Select 3, or a low strobe, returns zero. Reads work at any privilege level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| acc_en_i | input | 1 | Register access strobe |
| acc_wr_i | input | 1 | Access is a write when high |
| acc_sel_i | input | 2 | Register select (0 lower TB, 1 upper TB, 2 decrementer) |
| acc_wdata_i | input | HALF_W (32) | Write data |
| priv_sup_i | input | 1 | Supervisor privilege flag |
| dec_ack_i | input | 1 | Clears the exception request |
| acc_rdata_o | output | HALF_W (32) | Read data for the selected register |
| priv_fault_o | output | 1 | Non-supervisor write attempt |
| dec_irq_o | output | 1 | Level-held decrementer exception request |

## Verification
Several events can fall in the same cycle: a software write to a register and the prescaler tick that would update it, a write to the lower half and the carry it would produce, and an acknowledge and a fresh expiry. The bench repeats writes over four consecutive cycles so that one of them lands on a tick. It holds the acknowledge input high across an expiry. A behavioural reference model predicts every cycle's read data, fault flag and request level, and each cycle is judged against it.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
    typedef enum logic [1:0] {
        REG_TB_LO = 2'd0,
        REG_TB_HI = 2'd1,
        REG_DEC   = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tbd_prescaler.sv
module tbd_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pre_st_t;

    pre_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign tick_o = &s_q.cnt;

    // R2
    tick_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> !tick_o);
endmodule

// File: rtl/tbd_timebase.sv
module tbd_timebase #(
    parameter int HALF_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [HALF_W-1:0] wdata_i,
    output logic [HALF_W-1:0] lo_o,
    output logic [HALF_W-1:0] hi_o
);
    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } tb_st_t;

    tb_st_t s_d, s_q;
    logic   carry;

    always_comb begin
        s_d   = s_q;
        carry = tick_i && (&s_q.lo) && !wr_lo_i;
        if (wr_lo_i)     s_d.lo = wdata_i;
        else if (tick_i) s_d.lo = s_q.lo + 1'b1;
        if (wr_hi_i)     s_d.hi = wdata_i;
        else if (carry)  s_d.hi = s_q.hi + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign lo_o = s_q.lo;
    assign hi_o = s_q.hi;

    // R3
    tb_carry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && (&lo_o) && !wr_lo_i && !wr_hi_i) |=> (hi_o == $past(hi_o) + 1'b1) && (lo_o == '0));

    // R4
    tb_lo_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_lo_i |=> lo_o == $past(wdata_i));

    // R4
    tb_hi_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_hi_i |=> hi_o == $past(wdata_i));
endmodule

// File: rtl/tbd_decrementer.sv
module tbd_decrementer #(
    parameter int DEC_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [DEC_W-1:0] wdata_i,
    input  logic             ack_i,
    output logic [DEC_W-1:0] cnt_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [DEC_W-1:0] cnt;
        logic             irq;
    } dec_st_t;

    dec_st_t          s_d, s_q;
    logic [DEC_W-1:0] down;
    logic             expire;

    always_comb begin
        s_d    = s_q;
        down   = s_q.cnt - 1'b1;
        expire = tick_i && !wr_i && !s_q.cnt[DEC_W-1] && down[DEC_W-1];
        if (wr_i)        s_d.cnt = wdata_i;
        else if (tick_i) s_d.cnt = down;
        if (expire)      s_d.irq = 1'b1;
        else if (ack_i)  s_d.irq = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.cnt <= '1;
            s_q.irq <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;
    assign irq_o = s_q.irq;

    // R7
    irq_rise_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(irq_o) |-> ($past(cnt_o) == '0) && (cnt_o == '1));

    // R7
    irq_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && !ack_i) |=> irq_o);

    // R8
    load_no_irq_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && !irq_o) |=> !irq_o);
endmodule

// File: rtl/tbd_timer_top.sv
module tbd_timer_top
    import tbd_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int DIV_W  = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              acc_en_i,
    input  logic              acc_wr_i,
    input  logic [1:0]        acc_sel_i,
    input  logic [HALF_W-1:0] acc_wdata_i,
    input  logic              priv_sup_i,
    input  logic              dec_ack_i,
    output logic [HALF_W-1:0] acc_rdata_o,
    output logic              priv_fault_o,
    output logic              dec_irq_o
);
    logic              tick;
    logic              sup_wr;
    logic              wr_lo, wr_hi, wr_dec;
    logic [HALF_W-1:0] tb_lo, tb_hi, dec_val;
    reg_sel_e          sel;

    assign sel          = reg_sel_e'(acc_sel_i);
    assign sup_wr       = acc_en_i && acc_wr_i && priv_sup_i;
    assign priv_fault_o = acc_en_i && acc_wr_i && !priv_sup_i;
    assign wr_lo        = sup_wr && (sel == REG_TB_LO);
    assign wr_hi        = sup_wr && (sel == REG_TB_HI);
    assign wr_dec       = sup_wr && (sel == REG_DEC);

    tbd_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (tick)
    );

    tbd_timebase #(.HALF_W(HALF_W)) u_tb (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tick_i  (tick),
        .wr_lo_i (wr_lo),
        .wr_hi_i (wr_hi),
        .wdata_i (acc_wdata_i),
        .lo_o    (tb_lo),
        .hi_o    (tb_hi)
    );

    tbd_decrementer #(.DEC_W(HALF_W)) u_dec (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tick_i  (tick),
        .wr_i    (wr_dec),
        .wdata_i (acc_wdata_i),
        .ack_i   (dec_ack_i),
        .cnt_o   (dec_val),
        .irq_o   (dec_irq_o)
    );

    always_comb begin
        acc_rdata_o = '0;
        if (acc_en_i) begin
            case (sel)
                REG_TB_LO: acc_rdata_o = tb_lo;
                REG_TB_HI: acc_rdata_o = tb_hi;
                REG_DEC:   acc_rdata_o = dec_val;
                default:   acc_rdata_o = '0;
            endcase
        end
    end

    // R5
    fault_blocks_wr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        priv_fault_o |-> !(wr_lo || wr_hi || wr_dec));

    // R5
    fault_keeps_hi_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (priv_fault_o && !tick) |=> $stable(tb_hi) && $stable(dec_val));
endmodule

// File: tb/tbd_timer_top_tb_top.sv
module tbd_timer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0, wr = 1'b0, sup = 1'b0, ack = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fault, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [63:0] m_tb;
    logic [31:0] m_dec;
    int          m_pre;
    bit          m_irq;
    logic [63:0] n_tb;
    bit          m_tick, m_w, m_set;

    always #2 clk = ~clk;

    tbd_timer_top dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .acc_en_i     (en),
        .acc_wr_i     (wr),
        .acc_sel_i    (sel),
        .acc_wdata_i  (wdata),
        .priv_sup_i   (sup),
        .dec_ack_i    (ack),
        .acc_rdata_o  (rdata),
        .priv_fault_o (fault),
        .dec_irq_o    (irq)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_tb = '0; m_dec = '1; m_irq = 1'b0;
        end else begin
            m_tick = (m_pre == 3);
            m_w    = en && wr && sup;
            m_set  = 1'b0;
            n_tb   = m_tick ? m_tb + 64'd1 : m_tb;
            if (m_w && sel == 2'd0) n_tb = {m_tb[63:32], wdata};
            if (m_w && sel == 2'd1) n_tb[63:32] = wdata;
            m_tb = n_tb;
            if (m_w && sel == 2'd2) m_dec = wdata;
            else if (m_tick) begin
                if (m_dec == 32'd0) m_set = 1'b1;
                m_dec = m_dec - 32'd1;
            end
            if (m_set) m_irq = 1'b1;
            else if (ack) m_irq = 1'b0;
            m_pre = (m_pre + 1) % 4;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd();
        if (!en) return '0;
        case (sel)
            2'd0: return m_tb[31:0];
            2'd1: return m_tb[63:32];
            2'd2: return m_dec;
            default: return '0;
        endcase
    endfunction

    task automatic cyc(bit e, bit w, logic [1:0] s, logic [31:0] d, bit su, bit a);
        @(negedge clk);
        en = e; wr = w; sel = s; wdata = d; sup = su; ack = a;
        #1;
        chk(cur_req, rdata, exp_rd());
        chk("R5", {31'd0, fault}, {31'd0, e && w && !su});
        chk("R7", {31'd0, irq}, {31'd0, m_irq});
    endtask

    task automatic rd(logic [1:0] s, int n);
        for (int i = 0; i < n; i++) cyc(1, 0, s, 32'h0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: state straight after reset
        cur_req = "R1";
        cyc(1, 0, 2'd0, 0, 0, 0);
        chk("R1", rdata, 32'h0);
        cyc(1, 0, 2'd2, 0, 0, 0);
        chk("R1", rdata, 32'hFFFF_FFFF);
        chk("R1", {31'd0, irq}, 32'd0);
        // R2: tick cadence seen through the lower half
        cur_req = "R2";
        rd(2'd0, 16);
        // R10: select decoding, strobe low, user-level reads
        cur_req = "R10";
        rd(2'd1, 2); rd(2'd2, 2); rd(2'd3, 2);
        for (int i = 0; i < 3; i++) cyc(0, 0, 2'd0, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(1, 0, 2'd2, 0, 1, 0);
        // R4: writes that hit a tick in one of four cycles
        cur_req = "R4";
        for (int i = 0; i < 4; i++) cyc(1, 1, 2'd0, 32'h1000 + i, 1, 0);
        rd(2'd0, 6);
        for (int i = 0; i < 4; i++) cyc(1, 1, 2'd1, 32'h50 + i, 1, 0);
        rd(2'd1, 4);
        // R4: lower half written at all ones over ticks, no carry
        for (int i = 0; i < 8; i++) cyc(1, 1, 2'd0, 32'hFFFF_FFFF, 1, 0);
        rd(2'd1, 2);
        // R3: carry from the lower half into the upper half
        cur_req = "R3";
        cyc(1, 1, 2'd0, 32'hFFFF_FFFE, 1, 0);
        for (int i = 0; i < 6; i++) begin rd(2'd0, 1); rd(2'd1, 1); end
        cyc(1, 1, 2'd1, 32'hFFFF_FFFF, 1, 0);
        cyc(1, 1, 2'd0, 32'hFFFF_FFFF, 1, 0);
        for (int i = 0; i < 5; i++) begin rd(2'd1, 1); rd(2'd0, 1); end
        // R5: user-level writes to every register are dropped
        cur_req = "R5";
        for (int i = 0; i < 4; i++) cyc(1, 1, 2'(i), 32'hDEAD_BEEF, 0, 0);
        rd(2'd0, 1); rd(2'd1, 1); rd(2'd2, 1);
        // R6 / R7: countdown to expiry, request held, then acknowledged
        cur_req = "R6";
        cyc(1, 1, 2'd2, 32'd3, 1, 0);
        rd(2'd2, 24);
        cur_req = "R7";
        rd(2'd2, 6);
        cyc(1, 0, 2'd2, 0, 0, 1);
        rd(2'd2, 3);
        // R8: loading a value with bit 31 set, and loading zero over ticks
        cur_req = "R8";
        for (int i = 0; i < 4; i++) cyc(1, 1, 2'd2, 32'h8000_0000, 1, 0);
        rd(2'd2, 4);
        for (int i = 0; i < 8; i++) cyc(1, 1, 2'd2, 32'h0, 1, 0);
        rd(2'd2, 2);
        // R9: acknowledge held across a fresh expiry
        cur_req = "R9";
        cyc(1, 1, 2'd2, 32'h1, 1, 0);
        for (int i = 0; i < 12; i++) cyc(1, 0, 2'd2, 0, 0, 1);
        cyc(1, 1, 2'd2, 32'h0, 1, 0);
        for (int i = 0; i < 6; i++) cyc(1, 0, 2'd2, 0, 0, 1);
        rd(2'd2, 2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule